// File: doc/BRIEF.md
# Digit Brightness and Blink Gate

This block decides, clock by clock, which of the eight digits of a multiplexed LED display may light. A 3-bit brightness code sets how many of the 15 slots in a repeating frame keep the digits lit. A slow timebase, divided from the clock, splits each blink period into an on half and an off half. A global blink enable and a per-digit flash attribute use that off half to darken digits.

The brightness code is sampled once per frame and applied from the next frame on. A new code therefore never cuts a frame short. Blink and flash enables and the flash attribute act combinationally on the current phase. A synchronous reset clears the frame and the blink counters. Several displays that leave reset on the same edge then stay in step.

Top module: `digit_dim_blink`

## Requirements
- R1: Code 0 keeps every digit lit in all 15 slots of a frame. Code 7 keeps every digit dark for the whole frame.
- R2: Codes 0 to 7 light the digits for 15, 12, 8, 6, 4, 3, 2 and 0 slots of the 15-slot frame. The lit slots are the leading ones: slot s is lit when s is below the count for the code. Slots are numbered 0 to 14 from the start of the frame.
- R3: A frame lasts 15 slots of SLOT_CLKS clocks each. The code present on the last clock of a frame governs the whole next frame. A change in the middle of a frame leaves the rest of that frame unchanged.
- R4: The blink period is BLINK_DIV clocks (28,672 by default). Its first BLINK_DIV/2 clocks form the on half, and the remaining clocks form the off half.
- R5: With blink enable at 1, every digit is dark during the off half, whatever the flash enable and flash attribute bits hold. During the on half, the digits follow the brightness duty.
- R6: With blink enable at 0 and flash enable at 1, digit d is dark during the off half when flash attribute bit d is 1. The other digits follow the brightness duty.
- R7: With blink enable and flash enable both at 0, the flash attribute has no effect, and all digits follow the brightness duty in both halves.
- R8: While synchronous reset is high, all digits are dark. After reset, the frame and the blink period both start at count 0 on the first clock. The first frame is blank, and the on half begins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bright_code_i | input | 3 | Brightness code, 0 brightest, 7 blank |
| flash_en_i | input | 1 | Enables the per-digit flash attribute |
| blink_en_i | input | 1 | Blinks all digits together, overriding flash |
| flash_mask_i | input | 8 | Flash attribute, one bit per digit |
| digit_on_o | output | 8 | Per-digit lit signal |

## Verification
Counting from the first clock after reset release as count 0, the frame slot is the count modulo 15. The blink phase is off when the count modulo 28,672 is at least 14,336. A code driven during a frame is checked against the old duty for the rest of that frame, and against the new duty over the whole following frame. The blink and flash enables and the flash attribute reach the output in the same cycle, with no register between them and the output. The bench keeps its own count from reset, drives inputs on the falling edge and samples the output on the falling edge. Each expected value is taken at the count where the two rules above place it.

// File: rtl/dispgate_pkg.sv
package dispgate_pkg;
  localparam int FRAME_SLOTS = 15;

  typedef logic [2:0] bright_code_t;
  typedef logic [3:0] slot_idx_t;

  localparam bright_code_t CODE_BLANK = 3'd7;

  // Lit slots per 15-slot frame for each brightness code.
  function automatic slot_idx_t lit_slots(input bright_code_t code);
    slot_idx_t n;
    case (code)
      3'd0:    n = 4'd15;
      3'd1:    n = 4'd12;
      3'd2:    n = 4'd8;
      3'd3:    n = 4'd6;
      3'd4:    n = 4'd4;
      3'd5:    n = 4'd3;
      3'd6:    n = 4'd2;
      default: n = 4'd0;
    endcase
    return n;
  endfunction

  function automatic logic slot_is_lit(input bright_code_t code, input slot_idx_t slot);
    return slot < lit_slots(code);
  endfunction
endpackage

// File: rtl/frame_duty.sv
module frame_duty
  import dispgate_pkg::*;
#(
  parameter int SLOT_CLKS = 1
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  bright_code_t code_i,
  output logic         lit_o,
  output logic         frame_end_o
);
  localparam int SUB_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam slot_idx_t LAST_SLOT = slot_idx_t'(FRAME_SLOTS - 1);

  slot_idx_t    slot_q;
  bright_code_t code_q;
  logic         slot_tick;

  generate
    if (SLOT_CLKS == 1) begin : g_single
      assign slot_tick = 1'b1;
    end else begin : g_multi
      logic [SUB_W-1:0] sub_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          sub_q <= '0;
        end else if (sub_q == SUB_W'(SLOT_CLKS - 1)) begin
          sub_q <= '0;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end
      assign slot_tick = (sub_q == SUB_W'(SLOT_CLKS - 1));
    end
  endgenerate

  assign frame_end_o = slot_tick && (slot_q == LAST_SLOT);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      slot_q <= '0;
      code_q <= CODE_BLANK;
    end else begin
      if (slot_tick) begin
        slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
      end
      if (frame_end_o) begin
        code_q <= code_i;
      end
    end
  end

  assign lit_o = slot_is_lit(code_q, slot_q);

  a_r1_blank_dark: assert property (@(posedge clk_i) disable iff (rst_i)
    (code_q == 3'd7) |-> !lit_o);
  a_r1_full_lit: assert property (@(posedge clk_i) disable iff (rst_i)
    (code_q == 3'd0) |-> lit_o);
  a_r3_slot_range: assert property (@(posedge clk_i) disable iff (rst_i)
    slot_q <= LAST_SLOT);
  a_r3_code_holds: assert property (@(posedge clk_i) disable iff (rst_i)
    (slot_q != '0) |-> $stable(code_q));
endmodule

// File: rtl/blink_timebase.sv
module blink_timebase #(
  parameter int BLINK_DIV = 28672
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic off_half_o
);
  localparam int CW   = $clog2(BLINK_DIV);
  localparam int HALF = BLINK_DIV / 2;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(BLINK_DIV - 1)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign off_half_o = (cnt_q >= CW'(HALF));

  a_r4_off_starts_mid: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(off_half_o) |-> (cnt_q == CW'(HALF)));
  a_r4_on_starts_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(off_half_o) |-> (cnt_q == '0));
endmodule

// File: rtl/digit_gate.sv
module digit_gate #(
  parameter int DIGITS = 8
) (
  input  logic              lit_i,
  input  logic              off_half_i,
  input  logic              blink_en_i,
  input  logic              flash_en_i,
  input  logic [DIGITS-1:0] flash_mask_i,
  output logic [DIGITS-1:0] digit_on_o
);
  logic [DIGITS-1:0] dark_now;

  generate
    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
      always_comb begin
        if (blink_en_i) begin
          dark_now[d] = off_half_i;
        end else if (flash_en_i && flash_mask_i[d]) begin
          dark_now[d] = off_half_i;
        end else begin
          dark_now[d] = 1'b0;
        end
      end
      assign digit_on_o[d] = lit_i && !dark_now[d];
    end
  endgenerate

  a_r7_mask_ignored: assert property (@(posedge lit_i)
    (!blink_en_i && !flash_en_i) |-> (dark_now == '0));
endmodule

// File: rtl/digit_dim_blink.sv
module digit_dim_blink
  import dispgate_pkg::*;
#(
  parameter int DIGITS    = 8,
  parameter int SLOT_CLKS = 1,
  parameter int BLINK_DIV = 28672
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [2:0]        bright_code_i,
  input  logic              flash_en_i,
  input  logic              blink_en_i,
  input  logic [DIGITS-1:0] flash_mask_i,
  output logic [DIGITS-1:0] digit_on_o
);
  logic lit;
  logic frame_end;
  logic off_half;

  frame_duty #(.SLOT_CLKS(SLOT_CLKS)) u_duty (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .code_i      (bright_code_i),
    .lit_o       (lit),
    .frame_end_o (frame_end)
  );

  blink_timebase #(.BLINK_DIV(BLINK_DIV)) u_blink (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .off_half_o (off_half)
  );

  digit_gate #(.DIGITS(DIGITS)) u_gate (
    .lit_i        (lit),
    .off_half_i   (off_half),
    .blink_en_i   (blink_en_i),
    .flash_en_i   (flash_en_i),
    .flash_mask_i (flash_mask_i),
    .digit_on_o   (digit_on_o)
  );

  a_r5_blink_dark: assert property (@(posedge clk_i) disable iff (rst_i)
    (blink_en_i && off_half) |-> (digit_on_o == '0));
  a_r6_flash_dark: assert property (@(posedge clk_i) disable iff (rst_i)
    (!blink_en_i && flash_en_i && off_half) |-> ((digit_on_o & flash_mask_i) == '0));
  a_r2_digits_agree: assert property (@(posedge clk_i) disable iff (rst_i)
    (!off_half) |-> ((digit_on_o == '0) || (&digit_on_o)));
  a_r3_frame_wrap_once: assert property (@(posedge clk_i) disable iff (rst_i)
    frame_end |=> !frame_end || (SLOT_CLKS * FRAME_SLOTS == 1));
endmodule

// File: tb/digit_dim_blink_tb.sv
module digit_dim_blink_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] code;
  logic       flash_en;
  logic       blink_en;
  logic [7:0] mask;
  logic [7:0] dout;

  int errors = 0;
  int checks = 0;
  int t = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  digit_dim_blink dut_i (
    .clk_i         (clk),
    .rst_i         (rst),
    .bright_code_i (code),
    .flash_en_i    (flash_en),
    .blink_en_i    (blink_en),
    .flash_mask_i  (mask),
    .digit_on_o    (dout)
  );

  always @(posedge clk) begin
    if (rst) t <= 0;
    else     t <= t + 1;
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual cycles=%0d expected fewer", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int exp_count(input int c);
    int tbl[8] = '{15, 12, 8, 6, 4, 3, 2, 0};
    return tbl[c];
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at t=%0d: actual=%h expected=%h", req, t, act, exp);
    end
  endtask

  task automatic go_t(input int n);
    while (t != n) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check8("R8 dark in reset", dout, 8'h00);
    rst = 1'b0;
  endtask

  // R8: first frame after reset is blank
  task automatic test_reset_frame;
    int bad = 0;
    for (int i = 0; i < 15; i++) begin
      go_t(i);
      if (dout !== 8'h00) bad++;
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL R8 first frame: actual lit samples=%0d expected=0", bad);
    end
  endtask

  // R1 R2 R3: duty per code, order of lit slots, code taking effect at frame edge
  task automatic test_duty;
    for (int c = 0; c < 8; c++) begin
      int base = 30 * (c + 1);
      int prev = (c == 0) ? 0 : c - 1;
      int cnt = 0;
      int bad = 0;
      go_t(base + 5);
      code = 3'(c);
      go_t(base + 10);
      check8("R3 mid-frame change held off", dout, (10 < exp_count(prev)) ? 8'hFF : 8'h00);
      for (int s = 0; s < 15; s++) begin
        go_t(base + 15 + s);
        if (dout == 8'hFF) cnt++;
        if (dout !== ((s < exp_count(c)) ? 8'hFF : 8'h00)) bad++;
      end
      checks++;
      if (cnt != exp_count(c)) begin
        errors++;
        $display("FAIL R2 lit count code %0d: actual=%0d expected=%0d", c, cnt, exp_count(c));
      end
      checks++;
      if (bad != 0) begin
        errors++;
        $display("FAIL R1 R2 slot order code %0d: actual bad slots=%0d expected=0", c, bad);
      end
    end
  endtask

  // R4 R5 R6 R7: blink and flash over one blink period
  task automatic test_blink_flash;
    go_t(300);
    code = 3'd0;
    go_t(320);
    mask = 8'h5A;
    check8("R7 mask ignored, on half", dout, 8'hFF);
    go_t(14000);
    flash_en = 1'b1;
    check8("R6 flash digits lit in on half", dout, 8'hFF);
    flash_en = 1'b0;
    go_t(14336);
    check8("R7 mask ignored, off half", dout, 8'hFF);
    go_t(14337);
    flash_en = 1'b1;
    mask = 8'hFF;
    go_t(14338);
    check8("R4 off half begins at 14336", dout, 8'h00);
    mask = 8'h5A;
    go_t(14340);
    check8("R6 flagged digits dark", dout, 8'hA5);
    blink_en = 1'b1;
    go_t(14350);
    check8("R5 blink overrides flash", dout, 8'h00);
    flash_en = 1'b0;
    mask = 8'h00;
    go_t(28671);
    check8("R5 blink dark without flash", dout, 8'h00);
    go_t(28672);
    check8("R4 on half resumes at 28672", dout, 8'hFF);
  endtask

  // R8: reset realigns the blink period
  task automatic test_realign;
    go_t(28700);
    do_reset();
    go_t(5);
    check8("R8 blank first frame after reset", dout, 8'h00);
    go_t(20);
    check8("R8 on half starts at release", dout, 8'hFF);
    go_t(14335);
    check8("R4 last on-half clock", dout, 8'hFF);
    go_t(14336);
    check8("R8 R5 realigned off half", dout, 8'h00);
  endtask

  initial begin
    rst = 1'b1;
    code = 3'd0;
    flash_en = 1'b0;
    blink_en = 1'b0;
    mask = 8'h00;
    do_reset();
    test_reset_frame();
    test_duty();
    test_blink_flash();
    test_realign();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule